// File: doc/BRIEF.md
# Multi-Format Iterative Divider

This block divides a dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder, producing one quotient bit per clock. One shared datapath serves five operand formats: signed and unsigned division of a 32-bit dividend, signed and unsigned division of a 16-bit dividend, and a signed Q15 fractional divide. The 32-bit dividend arrives as two 16-bit words, a low word and the word above it.

A one-cycle `start_i` request captures the format and operands. A setup cycle then takes magnitudes, extends 16-bit dividends and, for the fractional format, scales the dividend. Eighteen restoring iterations follow. Every format uses the same iteration count, so a divide always takes 19 working cycles. A single `done_o` pulse then marks the cycle in which sign-corrected results appear. The results and the divide-by-zero flag stay on the outputs until the next accepted request.

The controller has four states. `ST_IDLE` waits for a request. `ST_PREP` prepares the operands. `ST_RUN` iterates. `ST_WRAP` raises done. The transitions are: `ST_IDLE` to `ST_PREP` on `start_i`, `ST_PREP` to `ST_RUN` always, `ST_RUN` to itself until the last iteration and then to `ST_WRAP`, and `ST_WRAP` to `ST_IDLE` always.

Top module: `multi_fmt_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `dz_o` are 0, and `quo_o` and `rem_o` are 0.
- R2: With `fmt_i` = 0 (signed 32-bit dividend `{dvd_hi_i, dvd_lo_i}`, signed divisor), the quotient truncates toward zero and the remainder has the sign of the dividend.
- R3: With `fmt_i` = 1 (unsigned 32-bit dividend `{dvd_hi_i, dvd_lo_i}`, unsigned divisor), the outputs are the unsigned quotient and remainder whenever the quotient fits 16 bits.
- R4: With `fmt_i` = 2, `dvd_lo_i` is sign-extended and divided by the signed divisor, using the R2 rounding and remainder sign. `dvd_hi_i` has no effect.
- R5: With `fmt_i` = 3 (and the unused codes 5 to 7), `dvd_lo_i` is zero-extended and divided unsigned. `dvd_hi_i` has no effect.
- R6: With `fmt_i` = 4, the operands are Q15 values with |dividend| < |divisor|. The quotient is the Q15 value of dividend/divisor truncated toward zero, and the remainder is dividend·2^15 − quotient·divisor.
- R7: If a request is sampled at clock edge k, `done_o` is high for exactly one cycle, between edges k+19 and k+20, and `busy_o` is high from edge k until edge k+20.
- R8: A request that arrives while `busy_o` is high is ignored. The operation in progress finishes at its original time with its original operands.
- R9: A zero divisor makes `dz_o` read 1 when done is raised. Quotient and remainder are then undefined but do not change until the next request. A later request with a nonzero divisor returns `dz_o` to 0.
- R10: Quotient, remainder and `dz_o` hold their values while the block is idle and no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a divide |
| fmt_i | input | 3 | Operand format code |
| dvd_lo_i | input | 16 | Dividend low word, or the whole dividend for 16-bit formats |
| dvd_hi_i | input | 16 | Dividend high word for 32-bit formats |
| dvs_i | input | 16 | Divisor |
| busy_o | output | 1 | A divide is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | 16 | Quotient |
| rem_o | output | 16 | Remainder |
| dz_o | output | 1 | The last divide had a zero divisor |

## Verification
The assertions assume that operands are captured only on an accepted request, so a request during `ST_RUN` or `ST_WRAP` must leave the divisor register alone. They also assume the partial remainder stays below the divisor whenever it started below it. That holds only if the caller keeps the quotient within 16 bits and, for the fractional format, |dividend| < |divisor|. The stimulus therefore draws integer operands whose quotients fit the 16-bit signed or unsigned range, and fractional operands that meet the magnitude rule. Zero divisors are used only in the divide-by-zero scenario, where only the flag and output stability are compared.

// File: rtl/mfdiv_pkg.sv
package mfdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2,
        ST_WRAP = 2'd3
    } dstate_e;

    typedef enum logic [2:0] {
        FMT_S32  = 3'd0,
        FMT_U32  = 3'd1,
        FMT_S16  = 3'd2,
        FMT_U16  = 3'd3,
        FMT_FRAC = 3'd4
    } fmt_e;

endpackage

// File: rtl/mfdiv_prep.sv
module mfdiv_prep
    import mfdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]     fmt,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   dv,
    output logic [2*W-1:0] mag_n,
    output logic [W-1:0]   mag_d,
    output logic           neg_q,
    output logic           neg_r,
    output logic           zero_d
);
    localparam int DW = 2 * W;

    logic [DW-1:0] ext;
    logic [DW-1:0] abs_n;
    logic          n_signed;
    logic          d_signed;
    logic          frac;
    logic          n_neg;
    logic          d_neg;

    // The format code decides how the dividend is widened and whether operands carry a sign.
    always_comb begin
        ext      = {{W{1'b0}}, lo};
        n_signed = 1'b0;
        d_signed = 1'b0;
        frac     = 1'b0;
        case (fmt)
            FMT_S32: begin
                ext      = {hi, lo};
                n_signed = 1'b1;
                d_signed = 1'b1;
            end
            FMT_U32: begin
                ext = {hi, lo};
            end
            FMT_S16: begin
                ext      = {{W{lo[W-1]}}, lo};
                n_signed = 1'b1;
                d_signed = 1'b1;
            end
            FMT_FRAC: begin
                ext      = {{W{lo[W-1]}}, lo};
                n_signed = 1'b1;
                d_signed = 1'b1;
                frac     = 1'b1;
            end
            default: begin
                ext = {{W{1'b0}}, lo};
            end
        endcase
    end

    always_comb begin
        n_neg  = n_signed & ext[DW-1];
        abs_n  = n_neg ? (~ext + 1'b1) : ext;
        mag_n  = frac ? (abs_n << (W - 1)) : abs_n;
        d_neg  = d_signed & dv[W-1];
        mag_d  = d_neg ? (~dv + 1'b1) : dv;
        neg_q  = n_neg ^ d_neg;
        neg_r  = n_neg;
        zero_d = (dv == '0);
    end

endmodule

// File: rtl/mfdiv_step.sv
module mfdiv_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] r_in,
    input  logic         bit_in,
    input  logic [W-1:0] d,
    output logic [W-1:0] r_out,
    output logic         q_bit
);
    logic [W:0] trial;
    logic [W:0] diff;

    // One restoring step: shift the next dividend bit in, then subtract the divisor if it fits.
    always_comb begin
        trial = {r_in, bit_in};
        diff  = trial - {1'b0, d};
        q_bit = (trial >= {1'b0, d});
        r_out = q_bit ? diff[W-1:0] : trial[W-1:0];
    end

    always_comb begin
        if (d != '0 && r_in < d) begin
            AST_STEP_REM_BOUND: assert (r_out < d); // R3
        end
    end

endmodule

// File: rtl/mfdiv_fix.sv
module mfdiv_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] q_raw,
    input  logic [W-1:0] r_raw,
    input  logic         neg_q,
    input  logic         neg_r,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out
);
    // The magnitudes are turned back into signed results: the quotient takes the XOR of the operand signs,
    // the remainder the dividend's sign.
    always_comb begin
        q_out = neg_q ? (~q_raw + 1'b1) : q_raw;
        r_out = neg_r ? (~r_raw + 1'b1) : r_raw;
    end

endmodule

// File: rtl/multi_fmt_divider.sv
module multi_fmt_divider
    import mfdiv_pkg::*;
#(
    parameter int W    = 16,
    parameter int ITER = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [2:0]   fmt_i,
    input  logic [W-1:0] dvd_lo_i,
    input  logic [W-1:0] dvd_hi_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         dz_o
);
    localparam int DW   = 2 * W;
    localparam int HI_W = DW - ITER;
    localparam int CW   = $clog2(ITER);
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    dstate_e        state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [W-1:0]   part_q;
    logic [ITER-1:0] shf_q;
    logic [W-1:0]   dvs_q;
    logic           negq_q, negr_q, dz_q;

    logic [2:0]     fmt_cap;
    logic [W-1:0]   hi_cap, lo_cap, dv_cap;

    logic [DW-1:0]  mag_n;
    logic [W-1:0]   mag_d;
    logic           neg_q, neg_r, zero_d;
    logic [W-1:0]   step_r;
    logic           step_q;

    mfdiv_prep #(.W(W)) u_prep (
        .fmt    (fmt_cap),
        .hi     (hi_cap),
        .lo     (lo_cap),
        .dv     (dv_cap),
        .mag_n  (mag_n),
        .mag_d  (mag_d),
        .neg_q  (neg_q),
        .neg_r  (neg_r),
        .zero_d (zero_d)
    );

    mfdiv_step #(.W(W)) u_step (
        .r_in   (part_q),
        .bit_in (shf_q[ITER-1]),
        .d      (dvs_q),
        .r_out  (step_r),
        .q_bit  (step_q)
    );

    mfdiv_fix #(.W(W)) u_fix (
        .q_raw (shf_q[W-1:0]),
        .r_raw (part_q),
        .neg_q (negq_q),
        .neg_r (negr_q),
        .q_out (quo_o),
        .r_out (rem_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_PREP;
            ST_PREP: state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_WRAP;
            ST_WRAP: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_WRAP);
        dz_o   = dz_q;
    end

    // Operand capture happens only on an accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_cap <= '0;
            hi_cap  <= '0;
            lo_cap  <= '0;
            dv_cap  <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            fmt_cap <= fmt_i;
            hi_cap  <= dvd_hi_i;
            lo_cap  <= dvd_lo_i;
            dv_cap  <= dvs_i;
        end
    end

    // Datapath: setup load, then one quotient bit per cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            part_q <= '0;
            shf_q  <= '0;
            dvs_q  <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            dz_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PREP: begin
                    part_q <= {{(W - HI_W){1'b0}}, mag_n[DW-1:ITER]};
                    shf_q  <= mag_n[ITER-1:0];
                    dvs_q  <= mag_d;
                    negq_q <= neg_q;
                    negr_q <= neg_r;
                    dz_q   <= zero_d;
                    cnt_q  <= '0;
                end
                ST_RUN: begin
                    part_q <= step_r;
                    shf_q  <= {shf_q[ITER-2:0], step_q};
                    cnt_q  <= cnt_q + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q < CW'(ITER))); // R7

    AST_PREP_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREP) |=> (state_q == ST_RUN && busy_o)); // R7

    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN || state_q == ST_WRAP) && start_i) |=> $stable(dvs_q)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> ($stable(quo_o) && $stable(rem_o) && $stable(dz_o))); // R10

endmodule

// File: tb/test_multi_fmt_divider.sv
module test_multi_fmt_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  fmt_i = '0;
    logic [15:0] dvd_lo_i = '0;
    logic [15:0] dvd_hi_i = '0;
    logic [15:0] dvs_i = '0;
    logic        busy_o, done_o, dz_o;
    logic [15:0] quo_o, rem_o;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    multi_fmt_divider i_multi_fmt_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .fmt_i    (fmt_i),
        .dvd_lo_i (dvd_lo_i),
        .dvd_hi_i (dvd_hi_i),
        .dvs_i    (dvs_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .quo_o    (quo_o),
        .rem_o    (rem_o),
        .dz_o     (dz_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expected(input logic [2:0] f, input logic [15:0] hi, input logic [15:0] lo,
                            input logic [15:0] dv, output logic [15:0] eq, output logic [15:0] er);
        longint n, d, q, r;
        case (f)
            3'd0: begin n = longint'($signed({hi, lo})); d = longint'($signed(dv)); end
            3'd1: begin n = longint'({hi, lo}); d = longint'(dv); end
            3'd2: begin n = longint'($signed(lo)); d = longint'($signed(dv)); end
            3'd4: begin n = longint'($signed(lo)) * 32768; d = longint'($signed(dv)); end
            default: begin n = longint'(lo); d = longint'(dv); end
        endcase
        q = n / d;
        r = n % d;
        eq = q[15:0];
        er = r[15:0];
    endtask

    task automatic launch(input logic [2:0] f, input logic [15:0] hi, input logic [15:0] lo,
                          input logic [15:0] dv);
        @(negedge clk);
        fmt_i = f; dvd_hi_i = hi; dvd_lo_i = lo; dvs_i = dv; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Waits 19 edges after the request edge; done must appear at the last one only.
    task automatic wait_done();
        logic early = 1'b0;
        logic idle_seen = 1'b0;
        for (int i = 1; i <= 19; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < 19 && done_o) early = 1'b1;
            if (!busy_o) idle_seen = 1'b1;
        end
        chk("R7 early done", early, 0);
        chk("R7 busy gap", idle_seen, 0);
        chk("R7 done", done_o, 1);
    endtask

    task automatic run_op(input logic [2:0] f, input logic [15:0] hi, input logic [15:0] lo,
                          input logic [15:0] dv, input string req);
        logic [15:0] eq, er;
        expected(f, hi, lo, dv, eq, er);
        launch(f, hi, lo, dv);
        wait_done();
        chk({req, " quotient"}, quo_o, eq);
        chk({req, " remainder"}, rem_o, er);
        chk({req, " dz"}, dz_o, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 done drop", done_o, 0);
        chk("R7 busy drop", busy_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 dz", dz_o, 0);
        chk("R1 quotient", quo_o, 0);
        chk("R1 remainder", rem_o, 0);
    endtask

    task automatic t_signed32();
        run_op(3'd0, 16'h0001, 16'h86A0, 16'hFFF9, "R2");
        run_op(3'd0, 16'hFFFE, 16'h7960, 16'h0007, "R2");
        run_op(3'd0, 16'hFFFE, 16'h7960, 16'hFFF9, "R2");
        for (int i = 0; i < 10; i++) begin
            longint n = longint'(i) * 73129 - 420000;
            longint d = longint'((i * 577) % 4000 + 150);
            logic [31:0] nv = n[31:0];
            if (i % 2 == 1) d = -d;
            run_op(3'd0, nv[31:16], nv[15:0], d[15:0], "R2 sweep");
        end
    endtask

    task automatic t_unsigned32();
        run_op(3'd1, 16'h7FFF, 16'hFFFF, 16'hFFFF, "R3");
        run_op(3'd1, 16'hFFFE, 16'h0001, 16'hFFFF, "R3");
        run_op(3'd1, 16'h0012, 16'h3456, 16'h1000, "R3");
    endtask

    task automatic t_short();
        run_op(3'd2, 16'h1234, 16'hFF38, 16'h0007, "R4");
        run_op(3'd2, 16'hBEEF, 16'h7FFF, 16'hFFFD, "R4");
        run_op(3'd3, 16'hA5A5, 16'hFF38, 16'h0007, "R5");
        run_op(3'd6, 16'hFFFF, 16'hFFFF, 16'h0100, "R5 spare code");
    endtask

    task automatic t_frac();
        run_op(3'd4, 16'h0000, 16'h2000, 16'h4000, "R6");
        run_op(3'd4, 16'h0000, 16'hF000, 16'h3000, "R6");
        run_op(3'd4, 16'hFFFF, 16'h1111, 16'h8000, "R6");
        run_op(3'd4, 16'h0000, 16'h7FFE, 16'h7FFF, "R6");
    endtask

    task automatic t_busy_ignore();
        logic [15:0] eq, er;
        logic early = 1'b0;
        expected(3'd0, 16'h0001, 16'h86A0, 16'hFFF9, eq, er);
        launch(3'd0, 16'h0001, 16'h86A0, 16'hFFF9);
        for (int i = 1; i <= 19; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < 19 && done_o) early = 1'b1;
            if (i == 5) begin
                fmt_i = 3'd3; dvd_hi_i = 16'h0; dvd_lo_i = 16'h0064; dvs_i = 16'h0003;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        chk("R8 early done", early, 0);
        chk("R8 done kept", done_o, 1);
        chk("R8 quotient", quo_o, eq);
        chk("R8 remainder", rem_o, er);
        @(posedge clk);
        @(negedge clk);
        chk("R8 no second run", busy_o, 0);
    endtask

    task automatic t_div_zero();
        logic [15:0] q0, r0;
        launch(3'd3, 16'h0000, 16'h1234, 16'h0000);
        wait_done();
        chk("R9 flag", dz_o, 1);
        q0 = quo_o;
        r0 = rem_o;
        repeat (6) @(negedge clk);
        chk("R9 quotient stable", quo_o, q0);
        chk("R9 remainder stable", rem_o, r0);
        chk("R9 flag held", dz_o, 1);
        run_op(3'd3, 16'h0000, 16'h0064, 16'h0003, "R9 clear");
    endtask

    task automatic t_hold();
        logic [15:0] q0, r0;
        run_op(3'd0, 16'hFFFF, 16'hFF00, 16'h0010, "R10 setup");
        q0 = quo_o;
        r0 = rem_o;
        fmt_i = 3'd1; dvd_lo_i = 16'h5555; dvd_hi_i = 16'h0; dvs_i = 16'h0;
        repeat (10) @(negedge clk);
        chk("R10 quotient", quo_o, q0);
        chk("R10 remainder", rem_o, r0);
        chk("R10 dz", dz_o, 0);
    endtask

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed32();
        t_unsigned32();
        t_short();
        t_frac();
        t_busy_ignore();
        t_div_zero();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule